// File: doc/BRIEF.md
# Tile Pixel Address Generator

This block turns one tilemap entry, together with the pixel row and column inside the tile, into three results. The first is the address of the tile-definition word that holds the pixel. The second says where the pixel sits in that word. The third is the colour attribute or palette offset that the later colour stage applies. It supports three colour depths: one bit, four bits and eight bits per pixel. In the one-bit depth it also supports a tall 8x16 tile.

The display pipeline presents a request with `in_valid` high. The results appear on the outputs one clock later, qualified by `out_valid`. The outputs keep their values while no request is presented.

The definition base is expected to sit on a boundary at least as large as the tile set for the chosen depth. The word address is therefore formed by OR-ing the tile offset into the base. Any base bit that is set remains set in the result.

Top module: `tile_pixel_addr`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by one clock. The results of a request appear in that same cycle. While `in_valid` is low, all result outputs hold their previous values.
- R2: `depth_sel` is decoded as follows: 0 selects one bit per pixel, 1 selects four bits per pixel, and both 2 and 3 select eight bits per pixel.
- R3: In the one-bit depth, the tilemap word is split into three fields. Bits [7:0] are the tile index, bits [11:8] are the background attribute (`attr_bg`) and bits [15:12] are the foreground attribute (`attr_fg`). For 8x8 tiles (`tall_tile`=0) the address is `def_base | {index, row[2:1]}`.
- R4: In the one-bit depth with `tall_tile`=1, the address is `def_base | {index, row[3:1]}`. Each definition word holds two tile rows.
- R5: In the one-bit depth, `pix_lane` is the column. `bit_shift` is 15 minus the column for an even row (high byte) and 7 minus the column for an odd row (low byte). Pixel 0 is therefore the MSB of its byte. `color_base` is 0.
- R6: In the four-bit depth, the address is `def_base | {index[9:0], row[2:0], col[2]}`. `pix_lane` is `col[1:0]` and `bit_shift` is 12 − 4·`col[1:0]`, so pixel 0 is the top nibble. The row and column used here are the mirrored ones when R8 applies.
- R7: In the eight-bit depth, the address is `def_base | {index[9:0], row[2:0], col[2:1]}`. `pix_lane` is `col[0]` and `bit_shift` is 8 for lane 0 and 0 for lane 1. The row and column used here are the mirrored ones when R8 applies.
- R8: In the four-bit and eight-bit depths, tilemap bit 10 mirrors horizontally, replacing the column with 7 − column. Bit 11 mirrors vertically, replacing `row[2:0]` with 7 − `row[2:0]`. In these depths `row[3]` and `tall_tile` have no effect. In the one-bit depth, bits 10 and 11 are attribute bits and cause no mirroring.
- R9: In the four-bit and eight-bit depths, `color_base` is `{map_word[15:12], 4'h0}`, which selects a 16-entry palette bank. `attr_fg` and `attr_bg` are 0.
- R10: The address is the bitwise OR of the base and the tile offset. A base bit inside the offset field that is set remains set.
- R11: After reset, `out_valid` and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| map_word | input | 16 | Tilemap entry |
| def_base | input | ADDR_W | Tile-definition base address |
| depth_sel | input | 2 | Colour depth select |
| tall_tile | input | 1 | 8x16 tile select (one-bit depth only) |
| tile_row | input | 4 | Pixel row inside the tile |
| tile_col | input | 3 | Pixel column inside the tile |
| out_valid | output | 1 | Result valid |
| word_addr | output | ADDR_W | Tile-definition word address |
| pix_lane | output | 3 | Pixel number inside the word or byte |
| bit_shift | output | 4 | LSB position of the pixel field in the word |
| attr_fg | output | 4 | Foreground attribute (one-bit depth) |
| attr_bg | output | 4 | Background attribute (one-bit depth) |
| color_base | output | 8 | Palette bank added to the colour index |

## Verification
The bench checks odd and even rows in the one-bit depth. A design that swapped the byte order would read the neighbouring row's pixels, which shows up as a `bit_shift` that is off by eight. It sets each mirror bit alone and then both together. A mirror applied to the wrong axis, or applied in the one-bit depth, moves both the address and the lane. It drives a set `row[3]` and `tall_tile` in the packed depths to show these inputs are dropped there. It also drives a base with low bits set, which separates an OR from an add.

// File: rtl/tpa_pkg.sv
package tpa_pkg;

  typedef enum logic [1:0] {
    DEPTH_MONO = 2'd0,
    DEPTH_NIB  = 2'd1,
    DEPTH_BYTE = 2'd2
  } depth_e;

  // depth_sel 2 and 3 both map to byte-per-pixel
  function automatic depth_e decode_depth(input logic [1:0] sel);
    depth_e d;
    case (sel)
      2'd0:    d = DEPTH_MONO;
      2'd1:    d = DEPTH_NIB;
      default: d = DEPTH_BYTE;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/tpa_map_decode.sv
module tpa_map_decode
  import tpa_pkg::*;
(
  input  logic [15:0] map_word,
  input  depth_e      depth,
  input  logic [3:0]  row_in,
  input  logic [2:0]  col_in,
  output logic [9:0]  tile_idx,
  output logic [3:0]  eff_row,
  output logic [2:0]  eff_col,
  output logic [3:0]  fg,
  output logic [3:0]  bg,
  output logic [7:0]  cbase
);

  logic hmir;
  logic vmir;

  always_comb begin
    hmir = map_word[10];
    vmir = map_word[11];
    if (depth == DEPTH_MONO) begin
      tile_idx = {2'b00, map_word[7:0]};
      eff_row  = row_in;
      eff_col  = col_in;
      bg       = map_word[11:8];
      fg       = map_word[15:12];
      cbase    = 8'h00;
    end else begin
      tile_idx = map_word[9:0];
      eff_row  = {1'b0, (vmir ? (3'd7 - row_in[2:0]) : row_in[2:0])};
      eff_col  = hmir ? (3'd7 - col_in) : col_in;
      bg       = 4'h0;
      fg       = 4'h0;
      cbase    = {map_word[15:12], 4'h0};
    end
  end

  // R8: packed depths never see row bit 3
  always_comb begin
    if (depth != DEPTH_MONO)
      assert_packed_row_R8: assert (eff_row[3] == 1'b0);
  end

endmodule

// File: rtl/tpa_addr_gen.sv
module tpa_addr_gen
  import tpa_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  depth_e            depth,
  input  logic              tall,
  input  logic [9:0]        tile_idx,
  input  logic [3:0]        eff_row,
  input  logic [2:0]        eff_col,
  input  logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] addr
);

  localparam int OFF_W = 15;

  logic [OFF_W-1:0] offset;

  always_comb begin
    case (depth)
      DEPTH_MONO: begin
        if (tall) offset = OFF_W'({tile_idx[7:0], eff_row[3:1]});
        else      offset = OFF_W'({tile_idx[7:0], eff_row[2:1]});
      end
      DEPTH_NIB:  offset = OFF_W'({tile_idx, eff_row[2:0], eff_col[2]});
      default:    offset = {tile_idx, eff_row[2:0], eff_col[2:1]};
    endcase
    addr = base | ADDR_W'(offset);
  end

endmodule

// File: rtl/tpa_lane_sel.sv
module tpa_lane_sel
  import tpa_pkg::*;
(
  input  depth_e     depth,
  input  logic [3:0] eff_row,
  input  logic [2:0] eff_col,
  output logic [2:0] lane,
  output logic [3:0] shift
);

  always_comb begin
    case (depth)
      DEPTH_MONO: begin
        lane  = eff_col;
        shift = {~eff_row[0], ~eff_col};
      end
      DEPTH_NIB: begin
        lane  = {1'b0, eff_col[1:0]};
        shift = {~eff_col[1:0], 2'b00};
      end
      default: begin
        lane  = {2'b00, eff_col[0]};
        shift = {~eff_col[0], 3'b000};
      end
    endcase
  end

endmodule

// File: rtl/tile_pixel_addr.sv
module tile_pixel_addr
  import tpa_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [15:0]       map_word,
  input  logic [ADDR_W-1:0] def_base,
  input  logic [1:0]        depth_sel,
  input  logic              tall_tile,
  input  logic [3:0]        tile_row,
  input  logic [2:0]        tile_col,
  output logic              out_valid,
  output logic [ADDR_W-1:0] word_addr,
  output logic [2:0]        pix_lane,
  output logic [3:0]        bit_shift,
  output logic [3:0]        attr_fg,
  output logic [3:0]        attr_bg,
  output logic [7:0]        color_base
);

  depth_e            depth;
  logic [9:0]        tile_idx;
  logic [3:0]        eff_row;
  logic [2:0]        eff_col;
  logic [3:0]        fg_n;
  logic [3:0]        bg_n;
  logic [7:0]        cbase_n;
  logic [ADDR_W-1:0] addr_n;
  logic [2:0]        lane_n;
  logic [3:0]        shift_n;

  assign depth = decode_depth(depth_sel);

  tpa_map_decode u_dec (
    .map_word (map_word),
    .depth    (depth),
    .row_in   (tile_row),
    .col_in   (tile_col),
    .tile_idx (tile_idx),
    .eff_row  (eff_row),
    .eff_col  (eff_col),
    .fg       (fg_n),
    .bg       (bg_n),
    .cbase    (cbase_n)
  );

  tpa_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .depth    (depth),
    .tall     (tall_tile),
    .tile_idx (tile_idx),
    .eff_row  (eff_row),
    .eff_col  (eff_col),
    .base     (def_base),
    .addr     (addr_n)
  );

  tpa_lane_sel u_lane (
    .depth (depth),
    .eff_row (eff_row),
    .eff_col (eff_col),
    .lane  (lane_n),
    .shift (shift_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_addr  <= '0;
      pix_lane   <= '0;
      bit_shift  <= '0;
      attr_fg    <= '0;
      attr_bg    <= '0;
      color_base <= '0;
    end else if (in_valid) begin
      word_addr  <= addr_n;
      pix_lane   <= lane_n;
      bit_shift  <= shift_n;
      attr_fg    <= fg_n;
      attr_bg    <= bg_n;
      color_base <= cbase_n;
    end
  end

  assert_valid_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(word_addr) && $stable(bit_shift) && $stable(color_base));

  assert_base_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((word_addr & $past(def_base)) == $past(def_base)));

  assert_mono_bank_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && depth_sel == 2'd0) |=> color_base == 8'h00);

  assert_nib_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && depth_sel == 2'd1) |=> (bit_shift[1:0] == 2'b00 && pix_lane[2] == 1'b0));

  assert_byte_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && depth_sel[1]) |=> (bit_shift[2:0] == 3'b000 && pix_lane[2:1] == 2'b00));

  assert_packed_attr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && depth_sel != 2'd0) |=> (attr_fg == 4'h0 && attr_bg == 4'h0));

endmodule

// File: tb/tb_tile_pixel_addr.sv
module tb_tile_pixel_addr;

  localparam int ADDR_W = 16;

  logic              clk;
  logic              rst_n;
  logic              in_valid;
  logic [15:0]       map_word;
  logic [ADDR_W-1:0] def_base;
  logic [1:0]        depth_sel;
  logic              tall_tile;
  logic [3:0]        tile_row;
  logic [2:0]        tile_col;
  logic              out_valid;
  logic [ADDR_W-1:0] word_addr;
  logic [2:0]        pix_lane;
  logic [3:0]        bit_shift;
  logic [3:0]        attr_fg;
  logic [3:0]        attr_bg;
  logic [7:0]        color_base;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  tile_pixel_addr #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .map_word(map_word),
    .def_base(def_base), .depth_sel(depth_sel), .tall_tile(tall_tile),
    .tile_row(tile_row), .tile_col(tile_col), .out_valid(out_valid),
    .word_addr(word_addr), .pix_lane(pix_lane), .bit_shift(bit_shift),
    .attr_fg(attr_fg), .attr_bg(attr_bg), .color_base(color_base)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Expected values built from the requirement text
  task automatic run_one(input string req, input logic [15:0] mw, input logic [15:0] base,
                         input logic [1:0] dsel, input logic tall,
                         input logic [3:0] r, input logic [2:0] c);
    int ea, el, es, efg, ebg, ecb, rr, cc, idx;
    @(negedge clk);
    in_valid = 1'b1; map_word = mw; def_base = base; depth_sel = dsel;
    tall_tile = tall; tile_row = r; tile_col = c;
    if (dsel == 2'd0) begin
      idx = mw & 8'hFF;
      ea  = tall ? (base | (idx * 8 + (r >> 1))) : (base | (idx * 4 + ((r & 7) >> 1)));
      el  = c;
      es  = (r % 2 == 0) ? 15 - c : 7 - c;
      efg = mw >> 12; ebg = (mw >> 8) & 4'hF; ecb = 0;
    end else begin
      idx = mw & 10'h3FF;
      rr  = mw[11] ? 7 - (r & 7) : (r & 7);
      cc  = mw[10] ? 7 - c : c;
      efg = 0; ebg = 0; ecb = (mw >> 12) * 16;
      if (dsel == 2'd1) begin
        ea = base | (idx * 16 + rr * 2 + (cc >> 2));
        el = cc % 4; es = 12 - 4 * (cc % 4);
      end else begin
        ea = base | (idx * 32 + rr * 4 + (cc >> 1));
        el = cc % 2; es = (cc % 2 == 0) ? 8 : 0;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    check("R1", {req, " valid"}, out_valid, 1);
    check(req, "word_addr", word_addr, ea);
    check(req, "pix_lane", pix_lane, el);
    check(req, "bit_shift", bit_shift, es);
    check(req, "attr_fg", attr_fg, efg);
    check(req, "attr_bg", attr_bg, ebg);
    check(req, "color_base", color_base, ecb);
  endtask

  task automatic t_reset;
    check("R11", "out_valid", out_valid, 0);
    check("R11", "word_addr", word_addr, 0);
    check("R11", "bit_shift", bit_shift, 0);
    check("R11", "color_base", color_base, 0);
  endtask

  task automatic t_mono;
    run_one("R3", 16'hA5_3C, 16'h0400, 2'd0, 1'b0, 4'd0, 3'd0);
    run_one("R5", 16'h7E_FF, 16'h0400, 2'd0, 1'b0, 4'd5, 3'd6);
    run_one("R5", 16'h1201, 16'h0C00, 2'd0, 1'b0, 4'd6, 3'd3);
    // bits 10/11 set: no mirroring in mono (R8)
    run_one("R8", 16'h0C10, 16'h0400, 2'd0, 1'b0, 4'd2, 3'd1);
  endtask

  task automatic t_tall;
    run_one("R4", 16'h98_FF, 16'h0800, 2'd0, 1'b1, 4'd15, 3'd2);
    run_one("R4", 16'h0003, 16'h0800, 2'd0, 1'b1, 4'd8, 3'd7);
  endtask

  task automatic t_nib;
    run_one("R6", 16'h5123, 16'h4000, 2'd1, 1'b0, 4'd3, 3'd5);
    run_one("R8", 16'h0523, 16'h4000, 2'd1, 1'b0, 4'd3, 3'd5);
    run_one("R8", 16'h0923, 16'h4000, 2'd1, 1'b1, 4'd11, 3'd1);
    run_one("R9", 16'hFF00, 16'h4000, 2'd1, 1'b0, 4'd7, 3'd0);
  endtask

  task automatic t_byte;
    run_one("R7", 16'h23FF, 16'h8000, 2'd2, 1'b0, 4'd1, 3'd4);
    run_one("R8", 16'h0C01, 16'h8000, 2'd2, 1'b1, 4'd2, 3'd6);
    run_one("R2", 16'hC0AA, 16'h8000, 2'd3, 1'b0, 4'd6, 3'd3);
  endtask

  task automatic t_or_base;
    run_one("R10", 16'h0005, 16'h0403, 2'd0, 1'b0, 4'd6, 3'd0);
    run_one("R10", 16'h0001, 16'h4011, 2'd1, 1'b0, 4'd0, 3'd4);
  endtask

  task automatic t_hold;
    logic [15:0] a0;
    logic [3:0]  s0;
    run_one("R1", 16'h0042, 16'h0400, 2'd0, 1'b0, 4'd1, 3'd1);
    a0 = word_addr; s0 = bit_shift;
    @(negedge clk);
    map_word = 16'hFFFF; tile_row = 4'd9; depth_sel = 2'd2; in_valid = 1'b0;
    @(negedge clk);
    check("R1", "hold valid low", out_valid, 0);
    check("R1", "hold addr", word_addr, a0);
    check("R1", "hold shift", bit_shift, s0);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; map_word = '0; def_base = '0;
    depth_sel = '0; tall_tile = 1'b0; tile_row = '0; tile_col = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_mono();
    t_tall();
    t_nib();
    t_byte();
    t_or_base();
    t_hold();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule